// File: doc/BRIEF.md
# Interleaved DRAM Address Range Decoder

This block maps a 40-bit physical address onto the memory system. Software programs up to eight ordered rules. Each rule holds only an upper limit, and its range starts where the preceding rule ends, or at zero for the first rule. The decoder takes the lowest-numbered rule whose limit lies above the address. The limit is compared against the top fourteen address bits, so ranges are sized in 64 MB steps.

When the matching rule is enabled, a 3-bit interleave index is formed from the address in one of three ways:
- plain cache-line bits;
- those bits XOR-folded with higher bits;
- a line bit combined with the line address taken modulo 3.

The index picks one of eight package IDs from that rule's own interleave list. The request is then reported as a DRAM hit for that package. Disabled ranges, addresses beyond every limit and rules set to the reserved mode are reported as MMIO.

Rule registers are written and read as whole dwords over a small configuration port. Interleave lists are loaded through a separate write port. The decode from address to outputs is purely combinational.

Top module: `dram_range_decoder`

## Requirements
- R1: The rule registers are dwords at byte offsets 80h + 4·n for n = 0..7. The offset must be dword aligned. Any other offset reads as zero, and a write to it changes no rule.
- R2: Within a rule register, bits 19:6 hold the limit, bits 2:1 hold the mode and bit 0 is the enable. Bits 31:20 and 5:3 always read zero. Every rule register resets to zero.
- R3: The decoder picks the lowest rule n whose limit is strictly greater than address bits 39:26. When such a rule exists, rule_idx reports n whether or not the rule is enabled.
- R4: If the matched rule is disabled, to_mmio is 1 and hit_dram is 0.
- R5: If no rule's limit exceeds address bits 39:26, then to_mmio is 1, hit_dram is 0, rule_idx is 0 and pkg_id is 0.
- R6: Mode 0 (bits 2:1 = 00) uses address bits 8:6 as the index, with bit 8 as the most significant.
- R7: Mode 1 (01) uses address bits 8:6 XOR address bits 18:16 as the index.
- R8: Mode 2 (10) builds the index with address bit 6 as the MSB. The lower two bits are the value of address bits 39:6 modulo 3.
- R9: An enabled matched rule in mode 3 (11) gives to_mmio = 1 and cfg_err = 1. In every other case cfg_err is 0.
- R10: A write with ilv_wr_en stores ilv_data in entry ilv_slot of the list for rule ilv_rule. Lists reset to zero. On a hit, pkg_id is entry [index] of the matched rule's list. Otherwise pkg_id is 0.
- R11: hit_dram and to_mmio are always complements of each other.
- R12: All decode outputs follow req_addr within the same cycle. A register or list write changes the decode only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Rule register write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Rule register write data |
| cfg_rdata | output | 32 | Rule register read data for cfg_addr |
| ilv_wr_en | input | 1 | Interleave list write strobe |
| ilv_rule | input | 3 | Rule whose list is written |
| ilv_slot | input | 3 | List entry written |
| ilv_data | input | 3 | Package ID written |
| req_addr | input | 40 | Physical address to decode |
| hit_dram | output | 1 | Address goes to DRAM of pkg_id |
| to_mmio | output | 1 | Address goes to the MMIO path |
| rule_idx | output | 3 | Matched rule, 0 if none |
| pkg_id | output | 3 | Selected package, 0 unless hit_dram |
| cfg_err | output | 1 | Matched enabled rule uses the reserved mode |

## Verification
There is no pipeline, so a corrupted rule field or list entry shows up at the ports in the same cycle as any address that falls in the affected range. It appears as a wrong rule_idx, a swapped hit/MMIO decision or a wrong pkg_id. A bad register write also shows on cfg_rdata right after the capturing edge. The vectors therefore cover every mode and both edges of each range. They read every register back, and they recheck the decode just before and just after each write lands.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

    localparam int N_RULES   = 8;
    localparam int ADDR_W    = 40;
    localparam int LIMIT_W   = 14;
    localparam int PKG_W     = 3;
    localparam int IDX_W     = 3;
    localparam int N_SLOTS   = 1 << IDX_W;
    localparam int LINE_LSB  = 6;
    localparam int FOLD_LSB  = 16;
    localparam int LIMIT_LSB = ADDR_W - LIMIT_W;
    localparam int MOD_IN_W  = ADDR_W - LINE_LSB;

    // register field positions, decoded by software
    localparam int F_EN      = 0;
    localparam int F_MODE_LO = 1;
    localparam int F_MODE_HI = 2;
    localparam int F_LIM_LO  = 6;
    localparam int F_LIM_HI  = F_LIM_LO + LIMIT_W - 1;

    typedef enum logic [1:0] {
        ILV_LINE  = 2'b00,
        ILV_FOLD  = 2'b01,
        ILV_MOD3  = 2'b10,
        ILV_RSVD  = 2'b11
    } ilv_mode_e;

    typedef struct packed {
        logic [LIMIT_W-1:0] limit;
        ilv_mode_e          mode;
        logic               en;
    } rule_t;

endpackage

// File: rtl/dram_mod3.sv
module dram_mod3 #(
    parameter int IN_W = 34
) (
    input  logic [IN_W-1:0] val,
    output logic [1:0]      res
);
    localparam int PAIRS = (IN_W + 1) / 2;
    localparam int SUM_W = $clog2(3 * PAIRS + 1);

    logic [2*PAIRS-1:0] padded;
    logic [SUM_W-1:0]   pair_sum;

    generate
        if (2 * PAIRS == IN_W) begin : g_even
            assign padded = val;
        end else begin : g_odd
            assign padded = {1'b0, val};
        end
    endgenerate

    // (2r + b) mod 3 for r in 0..2
    function automatic logic [1:0] step(input logic [1:0] r, input logic b);
        logic [2:0] t;
        t = {r, 1'b0} + {2'b00, b};
        return (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
    endfunction

    always_comb begin
        logic [1:0] r;
        // 4 == 1 (mod 3): each 2-bit digit contributes its own value
        pair_sum = '0;
        for (int p = 0; p < PAIRS; p++) begin
            pair_sum = pair_sum + SUM_W'(padded[2*p +: 2]);
        end
        r = 2'd0;
        for (int b = SUM_W - 1; b >= 0; b--) begin
            r = step(r, pair_sum[b]);
        end
        res = r;
    end

endmodule

// File: rtl/dram_ilv_index.sv
module dram_ilv_index
    import dram_dec_pkg::*;
(
    input  ilv_mode_e           mode,
    input  logic [MOD_IN_W-1:0] line_addr,
    output logic [IDX_W-1:0]    idx,
    output logic                rsvd
);
    logic [1:0] line_res;

    dram_mod3 #(.IN_W(MOD_IN_W)) u_mod3 (
        .val (line_addr),
        .res (line_res)
    );

    always_comb begin
        rsvd = 1'b0;
        unique case (mode)
            ILV_LINE: idx = line_addr[IDX_W-1:0];
            ILV_FOLD: idx = line_addr[IDX_W-1:0]
                          ^ line_addr[FOLD_LSB-LINE_LSB +: IDX_W];
            ILV_MOD3: idx = {line_addr[0], line_res};
            default: begin
                idx  = '0;
                rsvd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dram_rule_match.sv
module dram_rule_match
    import dram_dec_pkg::*;
#(
    parameter int NR = N_RULES,
    localparam int RW = $clog2(NR)
) (
    input  rule_t [NR-1:0]      rules,
    input  logic [LIMIT_W-1:0]  addr_top,
    output logic                found,
    output logic [RW-1:0]       idx
);
    // descending scan: the lowest matching rule is written last and wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (addr_top < rules[i].limit) begin
                found = 1'b1;
                idx   = RW'(i);
            end
        end
    end

endmodule

// File: rtl/dram_rule_regs.sv
module dram_rule_regs
    import dram_dec_pkg::*;
#(
    parameter int                NR       = N_RULES,
    parameter int                CFG_AW   = 8,
    parameter logic [CFG_AW-1:0] CFG_BASE = 8'h80,
    localparam int RW = $clog2(NR)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_wr_en,
    input  logic [CFG_AW-1:0]                     cfg_addr,
    input  logic [31:0]                           cfg_wdata,
    output logic [31:0]                           cfg_rdata,
    input  logic                                  ilv_wr_en,
    input  logic [RW-1:0]                         ilv_rule,
    input  logic [IDX_W-1:0]                      ilv_slot,
    input  logic [PKG_W-1:0]                      ilv_data,
    output rule_t [NR-1:0]                        rules_o,
    output logic [NR-1:0][N_SLOTS-1:0][PKG_W-1:0] ilv_o
);
    typedef struct packed {
        rule_t [NR-1:0]                        rule;
        logic [NR-1:0][N_SLOTS-1:0][PKG_W-1:0] ilv;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [CFG_AW-1:0] cfg_off;
    logic              cfg_hit;
    logic [RW-1:0]     cfg_slot;
    logic              unused_wbits;

    assign unused_wbits = ^{cfg_wdata[31:F_LIM_HI+1],
                            cfg_wdata[F_LIM_LO-1:F_MODE_HI+1]};

    always_comb begin
        cfg_off  = cfg_addr - CFG_BASE;
        cfg_hit  = (cfg_addr >= CFG_BASE) && (cfg_off[1:0] == 2'b00)
                && (int'(cfg_off >> 2) < NR);
        cfg_slot = RW'(cfg_off >> 2);

        regs_d = regs_q;
        if (cfg_wr_en && cfg_hit) begin
            regs_d.rule[cfg_slot].limit = cfg_wdata[F_LIM_HI:F_LIM_LO];
            regs_d.rule[cfg_slot].mode  = ilv_mode_e'(cfg_wdata[F_MODE_HI:F_MODE_LO]);
            regs_d.rule[cfg_slot].en    = cfg_wdata[F_EN];
        end
        if (ilv_wr_en) begin
            regs_d.ilv[ilv_rule][ilv_slot] = ilv_data;
        end

        cfg_rdata = '0;
        if (cfg_hit) begin
            cfg_rdata[F_LIM_HI:F_LIM_LO]   = regs_q.rule[cfg_slot].limit;
            cfg_rdata[F_MODE_HI:F_MODE_LO] = regs_q.rule[cfg_slot].mode;
            cfg_rdata[F_EN]                = regs_q.rule[cfg_slot].en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rules_o = regs_q.rule;
    assign ilv_o   = regs_q.ilv;

endmodule

// File: rtl/dram_range_decoder.sv
module dram_range_decoder
    import dram_dec_pkg::*;
#(
    parameter int NR = N_RULES,
    localparam int RW = $clog2(NR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [7:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                ilv_wr_en,
    input  logic [RW-1:0]       ilv_rule,
    input  logic [IDX_W-1:0]    ilv_slot,
    input  logic [PKG_W-1:0]    ilv_data,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                hit_dram,
    output logic                to_mmio,
    output logic [RW-1:0]       rule_idx,
    output logic [PKG_W-1:0]    pkg_id,
    output logic                cfg_err
);
    rule_t [NR-1:0]                        rules;
    logic [NR-1:0][N_SLOTS-1:0][PKG_W-1:0] ilv;
    logic                                  found;
    logic [RW-1:0]                         match_idx;
    rule_t                                 sel;
    logic [IDX_W-1:0]                      ilv_idx;
    logic                                  mode_rsvd;
    logic                                  unused_low;

    assign unused_low = ^req_addr[LINE_LSB-1:0];

    dram_rule_regs #(.NR(NR), .CFG_AW(8), .CFG_BASE(8'h80)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ilv_wr_en (ilv_wr_en),
        .ilv_rule  (ilv_rule),
        .ilv_slot  (ilv_slot),
        .ilv_data  (ilv_data),
        .rules_o   (rules),
        .ilv_o     (ilv)
    );

    dram_rule_match #(.NR(NR)) u_match (
        .rules    (rules),
        .addr_top (req_addr[ADDR_W-1:LIMIT_LSB]),
        .found    (found),
        .idx      (match_idx)
    );

    assign sel = rules[match_idx];

    dram_ilv_index u_index (
        .mode      (sel.mode),
        .line_addr (req_addr[ADDR_W-1:LINE_LSB]),
        .idx       (ilv_idx),
        .rsvd      (mode_rsvd)
    );

    always_comb begin
        hit_dram = found && sel.en && !mode_rsvd;
        to_mmio  = !hit_dram;
        cfg_err  = found && sel.en && mode_rsvd;
        rule_idx = found ? match_idx : '0;
        pkg_id   = hit_dram ? ilv[match_idx][ilv_idx] : '0;
    end

endmodule

// File: rtl/dram_range_decoder_chk.sv
module dram_range_decoder_chk
    import dram_dec_pkg::*;
#(
    parameter int NR = N_RULES,
    localparam int RW = $clog2(NR)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic [7:0]          cfg_addr,
    input logic [31:0]         cfg_wdata,
    input logic [31:0]         cfg_rdata,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                hit_dram,
    input logic                to_mmio,
    input logic [RW-1:0]       rule_idx,
    input logic [PKG_W-1:0]    pkg_id,
    input logic                cfg_err,
    input rule_t [NR-1:0]      rules
);
    logic          wr_hit;
    logic [RW-1:0] wr_slot;

    assign wr_hit  = cfg_wr_en && (cfg_addr[1:0] == 2'b00)
                  && (cfg_addr >= 8'h80) && (int'(cfg_addr) < 32'h80 + 4 * NR);
    assign wr_slot = RW'((cfg_addr - 8'h80) >> 2);

    p_wr_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (rules[$past(wr_slot)].limit == $past(cfg_wdata[F_LIM_HI:F_LIM_LO]))
                && (rules[$past(wr_slot)].en == $past(cfg_wdata[F_EN])));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[31:F_LIM_HI+1] == '0) && (cfg_rdata[F_LIM_LO-1:F_MODE_HI+1] == '0));

    p_hit_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dram |-> (req_addr[ADDR_W-1:LIMIT_LSB] < rules[rule_idx].limit));

    p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dram |-> rules[rule_idx].en);

    p_err_mmio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (to_mmio && rules[rule_idx].mode == ILV_RSVD));

    p_pkg_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_dram |-> (pkg_id == '0));

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dram != to_mmio);

endmodule

bind dram_range_decoder dram_range_decoder_chk #(.NR(NR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_addr  (req_addr),
    .hit_dram  (hit_dram),
    .to_mmio   (to_mmio),
    .rule_idx  (rule_idx),
    .pkg_id    (pkg_id),
    .cfg_err   (cfg_err),
    .rules     (rules)
);

// File: tb/dram_range_decoder_test.sv
module dram_range_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ilv_wr_en = 1'b0;
    logic [2:0]  ilv_rule = '0;
    logic [2:0]  ilv_slot = '0;
    logic [2:0]  ilv_data = '0;
    logic [39:0] req_addr = '0;
    logic        hit_dram, to_mmio, cfg_err;
    logic [2:0]  rule_idx, pkg_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_range_decoder uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .ilv_wr_en(ilv_wr_en), .ilv_rule(ilv_rule), .ilv_slot(ilv_slot),
        .ilv_data(ilv_data),
        .req_addr(req_addr), .hit_dram(hit_dram), .to_mmio(to_mmio),
        .rule_idx(rule_idx), .pkg_id(pkg_id), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [13:0] top;
        logic [25:0] low;
        logic        hit;
        logic [2:0]  rule;
        logic [2:0]  pkg;
        logic        err;
    } vec_t;

    // rules: 0 lim2 line, 1 lim4 fold, 2 lim5 off, 3 lim8 mod3, 4 lim9 reserved
    localparam vec_t VECS [13] = '{
        {14'd0,    26'h000_01C0, 1'b1, 3'd0, 3'd5, 1'b0},  // R6 idx 7
        {14'd1,    26'h000_0080, 1'b1, 3'd0, 3'd4, 1'b0},  // R6 idx 2
        {14'd1,    26'h3FF_FFFF, 1'b1, 3'd0, 3'd5, 1'b0},  // R3 just under limit
        {14'd2,    26'h003_0140, 1'b1, 3'd1, 3'd3, 1'b0},  // R7 idx 6
        {14'd3,    26'h000_0000, 1'b1, 3'd1, 3'd5, 1'b0},  // R7 idx 0
        {14'd4,    26'h000_0000, 1'b0, 3'd2, 3'd0, 1'b0},  // R4 disabled
        {14'd5,    26'h000_0000, 1'b1, 3'd3, 3'd5, 1'b0},  // R8 idx 2
        {14'd6,    26'h000_0040, 1'b1, 3'd3, 3'd4, 1'b0},  // R8 idx 5
        {14'd7,    26'h000_0080, 1'b1, 3'd3, 3'd3, 1'b0},  // R8 idx 0
        {14'd5,    26'h3FF_FFC0, 1'b1, 3'd3, 3'd1, 1'b0},  // R8 idx 6
        {14'd8,    26'h000_0000, 1'b0, 3'd4, 3'd0, 1'b1},  // R9 reserved
        {14'd9,    26'h000_0000, 1'b0, 3'd0, 3'd0, 1'b0},  // R5 above all
        {14'h3FFF, 26'h3FF_FFFF, 1'b0, 3'd0, 3'd0, 1'b0}   // R5 top address
    };

    function automatic logic [2:0] list_val(input int r, input int s);
        return 3'((r * 3 + s * 5 + 2) % 8);
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_rule(input int n, input logic [13:0] lim, input logic [1:0] md,
                           input logic en);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = 8'(8'h80 + 4 * n);
        cfg_wdata = {12'h000, lim, 3'b000, md, en};
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #2;
        check(req, 40'(cfg_rdata), 40'(exp));
    endtask

    task automatic decode_check(input string req, input logic [39:0] a, input logic hit,
                                input logic [2:0] rule, input logic [2:0] pkg,
                                input logic err);
        @(negedge clk);
        req_addr = a;
        #2;
        check({req, " hit"},  40'(hit_dram), 40'(hit));
        check({req, " mmio"}, 40'(to_mmio),  40'(!hit));
        check({req, " rule"}, 40'(rule_idx), 40'(rule));
        check({req, " pkg"},  40'(pkg_id),   40'(pkg));
        check({req, " err"},  40'(cfg_err),  40'(err));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state of all rule registers
        for (int n = 0; n < 8; n++) rd_check("R2 reset read", 8'(8'h80 + 4 * n), 32'h0);
        // R5 all limits zero: nothing matches
        decode_check("R5 after reset", 40'h0, 1'b0, 3'd0, 3'd0, 1'b0);

        // R10 program every interleave list
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                ilv_wr_en = 1'b1;
                ilv_rule  = 3'(r);
                ilv_slot  = 3'(s);
                ilv_data  = list_val(r, s);
            end
        end
        @(negedge clk);
        ilv_wr_en = 1'b0;

        wr_rule(0, 14'd2, 2'b00, 1'b1);
        wr_rule(1, 14'd4, 2'b01, 1'b1);
        wr_rule(2, 14'd5, 2'b00, 1'b0);
        wr_rule(3, 14'd8, 2'b10, 1'b1);
        wr_rule(4, 14'd9, 2'b11, 1'b1);

        // R1 read back programmed rules
        rd_check("R1 rule1 read", 8'h84, 32'h0000_0103);
        rd_check("R1 rule3 read", 8'h8C, 32'h0000_0205);

        // vector table: R3..R11
        foreach (VECS[i]) begin
            decode_check($sformatf("R3 vector %0d", i), {VECS[i].top, VECS[i].low},
                         VECS[i].hit, VECS[i].rule, VECS[i].pkg, VECS[i].err);
        end

        // R2 reserved bits read zero after an all-ones write
        wr_raw(8'h9C, 32'hFFFF_FFFF);
        rd_check("R2 reserved mask", 8'h9C, 32'h000F_FFC7);
        wr_raw(8'h9C, 32'h0);

        // R1 unmapped and unaligned offsets: no effect
        wr_raw(8'hA0, 32'hFFFF_FFFF);
        rd_check("R1 offset A0 reads zero", 8'hA0, 32'h0);
        wr_raw(8'h81, 32'h0000_0001);
        rd_check("R1 unaligned reads zero", 8'h81, 32'h0);
        wr_raw(8'h7C, 32'h0000_0000);
        rd_check("R1 rule0 untouched", 8'h80, 32'h0000_0081);
        decode_check("R1 decode untouched", 40'h0_0000_01C0, 1'b1, 3'd0, 3'd5, 1'b0);

        // R12 write takes effect only after its capturing edge
        @(negedge clk);
        req_addr  = 40'h0_0000_01C0;
        cfg_wr_en = 1'b1;
        cfg_addr  = 8'h80;
        cfg_wdata = 32'h0000_0080;          // limit 2, disabled
        #2;
        check("R12 before edge hit", 40'(hit_dram), 40'h1);
        @(posedge clk);
        #2;
        cfg_wr_en = 1'b0;
        check("R12 after edge mmio", 40'(to_mmio), 40'h1);
        check("R4 disabled rule idx", 40'(rule_idx), 40'h0);
        check("R4 disabled pkg", 40'(pkg_id), 40'h0);

        // R10 lists reset together with rules
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R2 read after reset", 8'h84, 32'h0);
        wr_rule(0, 14'd1, 2'b00, 1'b1);
        decode_check("R10 list reset", 40'h0_0000_01C0, 1'b1, 3'd0, 3'd0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule